// File: doc/BRIEF.md
# Hardware Breakpoint and Single-Step Trap Unit

This block sits beside the fetch and load/store stages of a small 32-bit core. It has four breakpoint address registers, a control word and a status word, all reached through a register port that only privilege level 0 may use. On every cycle it compares the instruction-fetch address and any data access (address, byte size, direction, memory or I/O space) against the armed breakpoints. A comparison is qualified by a 2-bit access-type code and a 2-bit length code for each breakpoint. A match raises a one-cycle debug-exception request in the following cycle and sets a sticky hit bit in the status word.

The unit also produces the single-step trap. The core reports each completed instruction with a retire strobe and shows its trap flag alongside it. The trap fires only on the second completed instruction that sees the flag set, so it lands one instruction after the instruction that set the flag. A resume input lets the core return to an address that holds a fetch breakpoint without trapping again at once. A cause code goes out with each request, and fetch breakpoints win over data breakpoints, which win over single-step.

Top module: `dbg_trap_unit`

## Requirements
- R1: After reset the status word reads 0xFFFF_1FF0, the control word and all address registers read 0, and `dbg_req_o` is 0.
- R2: At privilege 0, select codes 0-3 read and write the four breakpoint addresses, select 4 the control word and select 5 the status word. In the control word only bits 7:0 and 31:16 are stored, and every other bit reads 0.
- R3: A register access with a privilege level other than 0 sets `reg_fault_o` in the same cycle, returns 0 on `reg_rdata_o` and changes no register.
- R4: Status bits 3:0 are the hit flags of breakpoints 3..0, bit 13 is a debug-register-access flag, bit 14 is the single-step flag and bit 15 is a task-switch flag. All other status bits always read 1.
- R5: Control bits 2i (local) and 2i+1 (global) arm breakpoint i, and either one alone is enough. A breakpoint with both bits clear never matches.
- R6: Breakpoint i takes its type from control bits 17+4i:16+4i and its length from bits 19+4i:18+4i. Type 00 matches an instruction fetch whose address falls in the aligned window at the breakpoint address. Length 00 gives a 1-byte window, 01 a 2-byte window and 11 a 4-byte window.
- R7: Length code 10 never matches, for any access type.
- R8: Data type 01 matches memory writes only, and type 11 matches memory reads and writes. Neither one matches fetches or I/O accesses. Type 10 matches I/O accesses only, and only while `dbg_ext_en_i` is 1.
- R9: A data access of 1, 2 or 4 bytes (size code 00, 01 or 11) matches if any of its bytes falls inside the breakpoint's aligned window.
- R10: While `resume_flag_i` is 1, fetch breakpoints are masked and data breakpoints still match.
- R11: A retire with `trap_flag_i`=1 arms the step logic, and a retire with the flag at 0 disarms it. A retire with the flag at 1 while armed produces a step trap, and that trap sets status bit 14.
- R12: Status flag bits are set only by hardware events or by a privileged write. A hit that lands in the same cycle as a status write stays set. Several hit bits may be set in one cycle.
- R13: `dbg_req_o` pulses in the cycle after any qualified match. `dbg_cause_o` then reads 01 for fetch, 10 for data or 11 for step, in that priority order, and reads 00 when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_ext_en_i | input | 1 | Debug-extensions enable, which allows I/O breakpoints |
| reg_req_i | input | 1 | Register port access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Write data |
| priv_lvl_i | input | 2 | Privilege level of the access |
| reg_rdata_o | output | 32 | Read data (combinational) |
| reg_fault_o | output | 1 | Privilege fault on this access |
| fetch_valid_i | input | 1 | Instruction fetch this cycle |
| fetch_addr_i | input | 32 | Fetch address |
| dacc_valid_i | input | 1 | Data access this cycle |
| dacc_addr_i | input | 32 | Data access start address |
| dacc_size_i | input | 2 | Size code 00/01/11 = 1/2/4 bytes |
| dacc_wr_i | input | 1 | Data access is a write |
| dacc_io_i | input | 1 | Data access is in I/O space |
| retire_i | input | 1 | One instruction completed |
| trap_flag_i | input | 1 | Processor trap flag |
| resume_flag_i | input | 1 | Processor resume flag |
| dbg_req_o | output | 1 | Debug-exception request pulse |
| dbg_cause_o | output | 2 | Cause of the request |

## Verification
The collision that matters is a fetch-breakpoint match in the same cycle as a step trap. The bench arms the step logic with one retire under the trap flag. It then drives a matching fetch together with a second such retire on one clock edge. It judges the result by seeing a single request with the fetch cause and by reading back both hit bit 0 and step bit 14 from the status word. A second collision is a status write in the same cycle as a breakpoint hit, and there the hit bit must survive the write.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;
  localparam int NUM_BP  = 4;
  localparam int XLEN    = 32;
  localparam int SEL_W   = 3;

  localparam logic [SEL_W-1:0] SEL_CTL  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;

  localparam int ST_BD = 13;
  localparam int ST_BS = 14;
  localparam int ST_BT = 15;

  localparam logic [XLEN-1:0] ST_DEF_MASK  = 32'h0000_E00F;
  localparam logic [XLEN-1:0] CTL_DEF_MASK = 32'hFFFF_00FF;

  localparam logic [1:0] LEN_1B  = 2'b00;
  localparam logic [1:0] LEN_2B  = 2'b01;
  localparam logic [1:0] LEN_BAD = 2'b10;
  localparam logic [1:0] LEN_4B  = 2'b11;

  localparam logic [1:0] KIND_EXEC = 2'b00;
  localparam logic [1:0] KIND_WR   = 2'b01;
  localparam logic [1:0] KIND_IO   = 2'b10;
  localparam logic [1:0] KIND_RW   = 2'b11;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_FETCH = 2'b01,
    CAUSE_DATA  = 2'b10,
    CAUSE_STEP  = 2'b11
  } cause_e;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] kind;
  } bp_fld_t;
endpackage

// File: rtl/dbg_regfile.sv
module dbg_regfile
  import dbg_trap_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_req,
  input  logic                   reg_we,
  input  logic [SEL_W-1:0]       reg_sel,
  input  logic [XLEN-1:0]        reg_wdata,
  input  logic [1:0]             priv_lvl,
  output logic [XLEN-1:0]        reg_rdata,
  output logic                   reg_fault,
  input  logic [NUM_BP-1:0]      hit_set,
  input  logic                   bs_set,
  output logic [XLEN-1:0]        bp_addr [NUM_BP],
  output logic [XLEN-1:0]        ctl_q,
  output logic [XLEN-1:0]        stat_q
);
  logic acc_ok;
  logic wr_ok;

  assign acc_ok    = reg_req && (priv_lvl == 2'd0);
  assign reg_fault = reg_req && (priv_lvl != 2'd0);
  assign wr_ok     = acc_ok && reg_we;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_addr
    logic            a_en;
    logic [XLEN-1:0] a_q;
    assign a_en = wr_ok && (reg_sel == SEL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    a_q <= '0;
      else if (a_en) a_q <= reg_wdata;
    end
    assign bp_addr[i] = a_q;
  end

  logic            ctl_en;
  logic [XLEN-1:0] ctl_nxt;
  always_comb begin
    ctl_en  = wr_ok && (reg_sel == SEL_CTL);
    ctl_nxt = reg_wdata & CTL_DEF_MASK;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_nxt;
  end

  logic            st_wr;
  logic            st_en;
  logic [XLEN-1:0] st_evt;
  logic [XLEN-1:0] st_nxt;
  always_comb begin
    st_wr         = wr_ok && (reg_sel == SEL_STAT);
    st_evt        = '0;
    st_evt[NUM_BP-1:0] = hit_set;
    st_evt[ST_BS] = bs_set;
    st_en         = st_wr || (|hit_set) || bs_set;
    st_nxt        = ((st_wr ? reg_wdata : stat_q) & ST_DEF_MASK) | st_evt;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stat_q <= '0;
    else if (st_en) stat_q <= st_nxt;
  end

  always_comb begin
    reg_rdata = '0;
    if (acc_ok) begin
      if (reg_sel < SEL_W'(NUM_BP))  reg_rdata = bp_addr[reg_sel[1:0]];
      else if (reg_sel == SEL_CTL)   reg_rdata = ctl_q;
      else if (reg_sel == SEL_STAT)  reg_rdata = stat_q | ~ST_DEF_MASK;
    end
  end
endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match
  import dbg_trap_pkg::*;
(
  input  logic [XLEN-1:0] bp_addr,
  input  logic            armed,
  input  bp_fld_t         fld,
  input  logic            ext_en,
  input  logic            fetch_valid,
  input  logic [XLEN-1:0] fetch_addr,
  input  logic            dacc_valid,
  input  logic [XLEN-1:0] dacc_addr,
  input  logic [1:0]      dacc_size,
  input  logic            dacc_wr,
  input  logic            dacc_io,
  output logic            fetch_hit,
  output logic            data_hit
);
  logic            len_ok;
  logic [XLEN-1:0] win_mask;
  logic            kind_ok;
  logic [2:0]      nbytes;
  logic            overlap;
  logic [XLEN-1:0] byte_addr;

  always_comb begin
    len_ok = (fld.len != LEN_BAD);
    case (fld.len)
      LEN_2B:  win_mask = ~XLEN'(1);
      LEN_4B:  win_mask = ~XLEN'(3);
      default: win_mask = '1;
    endcase
  end

  assign fetch_hit = armed && len_ok && fetch_valid && (fld.kind == KIND_EXEC) &&
                     (((fetch_addr ^ bp_addr) & win_mask) == '0);

  always_comb begin
    case (fld.kind)
      KIND_WR: kind_ok = dacc_wr && !dacc_io;
      KIND_RW: kind_ok = !dacc_io;
      KIND_IO: kind_ok = ext_en && dacc_io;
      default: kind_ok = 1'b0;
    endcase
    case (dacc_size)
      2'b00:   nbytes = 3'd1;
      2'b01:   nbytes = 3'd2;
      2'b11:   nbytes = 3'd4;
      default: nbytes = 3'd0;
    endcase
    overlap = 1'b0;
    for (int k = 0; k < 4; k++) begin
      byte_addr = dacc_addr + XLEN'(k);
      if ((3'(k) < nbytes) && (((byte_addr ^ bp_addr) & win_mask) == '0))
        overlap = 1'b1;
    end
  end

  assign data_hit = armed && len_ok && dacc_valid && kind_ok && overlap;
endmodule

// File: rtl/dbg_trap_ctrl.sv
module dbg_trap_ctrl
  import dbg_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire,
  input  logic              trap_flag,
  input  logic              resume_flag,
  input  logic [NUM_BP-1:0] fetch_raw,
  input  logic [NUM_BP-1:0] data_raw,
  output logic [NUM_BP-1:0] hit_set,
  output logic              step_hit,
  output logic              trig_any,
  output logic              fetch_any,
  output logic              dbg_req,
  output cause_e            dbg_cause
);
  logic [NUM_BP-1:0] fetch_q;
  logic              data_any;
  logic              step_arm_q;
  logic              step_arm_nxt;
  logic              req_nxt;
  cause_e            cause_nxt;

  always_comb begin
    fetch_q      = resume_flag ? '0 : fetch_raw;
    fetch_any    = |fetch_q;
    data_any     = |data_raw;
    hit_set      = fetch_q | data_raw;
    step_hit     = retire && trap_flag && step_arm_q;
    step_arm_nxt = trap_flag;
    trig_any     = fetch_any || data_any || step_hit;
    req_nxt      = trig_any;
    if (fetch_any)     cause_nxt = CAUSE_FETCH;
    else if (data_any) cause_nxt = CAUSE_DATA;
    else if (step_hit) cause_nxt = CAUSE_STEP;
    else               cause_nxt = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_arm_q <= 1'b0;
    else if (retire) step_arm_q <= step_arm_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_req   <= 1'b0;
      dbg_cause <= CAUSE_NONE;
    end else begin
      dbg_req   <= req_nxt;
      dbg_cause <= cause_nxt;
    end
  end
endmodule

// File: rtl/dbg_trap_unit.sv
module dbg_trap_unit
  import dbg_trap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dbg_ext_en_i,
  input  logic        reg_req_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  input  logic [1:0]  priv_lvl_i,
  output logic [31:0] reg_rdata_o,
  output logic        reg_fault_o,
  input  logic        fetch_valid_i,
  input  logic [31:0] fetch_addr_i,
  input  logic        dacc_valid_i,
  input  logic [31:0] dacc_addr_i,
  input  logic [1:0]  dacc_size_i,
  input  logic        dacc_wr_i,
  input  logic        dacc_io_i,
  input  logic        retire_i,
  input  logic        trap_flag_i,
  input  logic        resume_flag_i,
  output logic        dbg_req_o,
  output logic [1:0]  dbg_cause_o
);
  logic [XLEN-1:0]   bp_addr [NUM_BP];
  logic [XLEN-1:0]   ctl_q;
  logic [XLEN-1:0]   stat_q;
  logic [NUM_BP-1:0] fetch_raw;
  logic [NUM_BP-1:0] data_raw;
  logic [NUM_BP-1:0] hit_set;
  logic              step_hit;
  logic              trig_any;
  logic              fetch_any;
  cause_e            cause;

  dbg_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_req   (reg_req_i),
    .reg_we    (reg_we_i),
    .reg_sel   (reg_sel_i),
    .reg_wdata (reg_wdata_i),
    .priv_lvl  (priv_lvl_i),
    .reg_rdata (reg_rdata_o),
    .reg_fault (reg_fault_o),
    .hit_set   (hit_set),
    .bs_set    (step_hit),
    .bp_addr   (bp_addr),
    .ctl_q     (ctl_q),
    .stat_q    (stat_q)
  );

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    bp_fld_t fld;
    logic    armed;
    assign armed = ctl_q[2*i] | ctl_q[2*i+1];
    assign fld   = bp_fld_t'(ctl_q[16+4*i +: 4]);
    dbg_bp_match u_match (
      .bp_addr     (bp_addr[i]),
      .armed       (armed),
      .fld         (fld),
      .ext_en      (dbg_ext_en_i),
      .fetch_valid (fetch_valid_i),
      .fetch_addr  (fetch_addr_i),
      .dacc_valid  (dacc_valid_i),
      .dacc_addr   (dacc_addr_i),
      .dacc_size   (dacc_size_i),
      .dacc_wr     (dacc_wr_i),
      .dacc_io     (dacc_io_i),
      .fetch_hit   (fetch_raw[i]),
      .data_hit    (data_raw[i])
    );
  end

  dbg_trap_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .retire      (retire_i),
    .trap_flag   (trap_flag_i),
    .resume_flag (resume_flag_i),
    .fetch_raw   (fetch_raw),
    .data_raw    (data_raw),
    .hit_set     (hit_set),
    .step_hit    (step_hit),
    .trig_any    (trig_any),
    .fetch_any   (fetch_any),
    .dbg_req     (dbg_req_o),
    .dbg_cause   (cause)
  );

  assign dbg_cause_o = cause;
endmodule

// File: rtl/dbg_trap_unit_chk.sv
module dbg_trap_unit_chk
  import dbg_trap_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        reg_req_i,
  input logic        reg_we_i,
  input logic [2:0]  reg_sel_i,
  input logic [1:0]  priv_lvl_i,
  input logic [31:0] reg_rdata_o,
  input logic        reg_fault_o,
  input logic [31:0] ctl_q,
  input logic [31:0] stat_q,
  input logic        trig_any,
  input logic        fetch_any,
  input logic        dbg_req_o,
  input logic [1:0]  dbg_cause_o
);
  logic stat_wr;
  assign stat_wr = reg_req_i && reg_we_i && (reg_sel_i == SEL_STAT) && (priv_lvl_i == 2'd0);

  // R3
  priv_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req_i && reg_we_i && priv_lvl_i != 2'd0) |=> $stable(ctl_q));

  // R3
  fault_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_fault_o |-> (reg_rdata_o == 32'd0));

  // R4
  rsvd_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req_i && !reg_we_i && reg_sel_i == SEL_STAT && !reg_fault_o)
      |-> ((reg_rdata_o | ST_DEF_MASK) == 32'hFFFF_FFFF));

  // R12
  hit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

  // R13
  req_after_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_o |-> $past(trig_any));

  // R13
  fetch_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_any |=> (dbg_req_o && dbg_cause_o == CAUSE_FETCH));

  // R13
  cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_req_o |-> (dbg_cause_o == CAUSE_NONE));
endmodule

bind dbg_trap_unit dbg_trap_unit_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .priv_lvl_i  (priv_lvl_i),
  .reg_rdata_o (reg_rdata_o),
  .reg_fault_o (reg_fault_o),
  .ctl_q       (ctl_q),
  .stat_q      (stat_q),
  .trig_any    (trig_any),
  .fetch_any   (fetch_any),
  .dbg_req_o   (dbg_req_o),
  .dbg_cause_o (dbg_cause_o)
);

// File: tb/dbg_trap_unit_tb_top.sv
`timescale 1ns/1ps
module dbg_trap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_en = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  priv = '0;
  logic [31:0] rdata;
  logic        fault;
  logic        fv = 1'b0;
  logic [31:0] fa = '0;
  logic        dv = 1'b0;
  logic [31:0] da = '0;
  logic [1:0]  dsz = '0;
  logic        dwr = 1'b0, dio = 1'b0;
  logic        ret = 1'b0, tf = 1'b0, rf = 1'b0;
  logic        req;
  logic [1:0]  cause;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbg_trap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_ext_en_i(ext_en),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .priv_lvl_i(priv), .reg_rdata_o(rdata),
    .reg_fault_o(fault), .fetch_valid_i(fv), .fetch_addr_i(fa),
    .dacc_valid_i(dv), .dacc_addr_i(da), .dacc_size_i(dsz),
    .dacc_wr_i(dwr), .dacc_io_i(dio), .retire_i(ret),
    .trap_flag_i(tf), .resume_flag_i(rf), .dbg_req_o(req),
    .dbg_cause_o(cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bpw(input int i, input logic l, input logic g,
                                      input logic [1:0] kind, input logic [1:0] len);
    logic [31:0] w = '0;
    w[2*i]   = l;
    w[2*i+1] = g;
    w[16+4*i +: 2] = kind;
    w[18+4*i +: 2] = len;
    return w;
  endfunction

  task automatic reg_wr(input logic [2:0] s, input logic [31:0] d, input logic [1:0] p = 2'd0);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_sel = s; reg_wdata = d; priv = p;
    @(posedge clk); #1;
    reg_req = 0; reg_we = 0; priv = 0;
  endtask

  task automatic reg_rd(input logic [2:0] s, output logic [31:0] d, input logic [1:0] p = 2'd0);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_sel = s; priv = p;
    #1 d = rdata;
    reg_req = 0; priv = 0;
  endtask

  // one cycle of core activity; returns request and cause seen after the edge
  task automatic cyc(input logic f_v, input logic [31:0] f_a,
                     input logic d_v, input logic [31:0] d_a, input logic [1:0] d_s,
                     input logic d_w, input logic d_io,
                     input logic r, input logic t, input logic rs,
                     output logic q, output logic [1:0] c);
    @(negedge clk);
    fv = f_v; fa = f_a; dv = d_v; da = d_a; dsz = d_s; dwr = d_w; dio = d_io;
    ret = r; tf = t; rf = rs;
    @(posedge clk); #1;
    q = req; c = cause;
    fv = 0; dv = 0; ret = 0; rf = 0; dwr = 0; dio = 0;
  endtask

  task automatic fetch(input logic [31:0] a, input logic rs, output logic q, output logic [1:0] c);
    cyc(1, a, 0, 0, 0, 0, 0, 0, tf, rs, q, c);
  endtask

  task automatic dacc(input logic [31:0] a, input logic [1:0] s, input logic w, input logic io,
                      output logic q, output logic [1:0] c);
    cyc(0, 0, 1, a, s, w, io, 0, tf, 0, q, c);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 req after reset", {31'd0, req}, 32'd0);
    reg_rd(3'd5, d); chk("R1 status reset", d, 32'hFFFF_1FF0);
    reg_rd(3'd4, d); chk("R1 ctl reset", d, 32'd0);
    reg_rd(3'd2, d); chk("R1 addr2 reset", d, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) reg_wr(3'(i), 32'hA000_0000 + 32'(i*16));
    for (int i = 0; i < 4; i++) begin
      reg_rd(3'(i), d); chk("R2 addr readback", d, 32'hA000_0000 + 32'(i*16));
    end
    reg_wr(3'd4, 32'hFFFF_FFFF);
    reg_rd(3'd4, d); chk("R2 ctl defined bits", d, 32'hFFFF_00FF);
    reg_wr(3'd4, 32'd0);
    reg_wr(3'd5, 32'h0000_A005);
    reg_rd(3'd5, d); chk("R4 status flags and ones", d, 32'hFFFF_BFF5);
    reg_wr(3'd5, 32'd0);
  endtask

  task automatic t_priv();
    logic [31:0] d;
    reg_wr(3'd1, 32'h1234_5678);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_sel = 3'd1; reg_wdata = 32'hDEAD_BEEF; priv = 2'd3;
    #1 chk("R3 write fault", {31'd0, fault}, 32'd1);
    @(posedge clk); #1; reg_req = 0; reg_we = 0; priv = 0;
    reg_rd(3'd1, d, 2'd1); chk("R3 read data zero", d, 32'd0);
    reg_rd(3'd1, d); chk("R3 register unchanged", d, 32'h1234_5678);
  endtask

  task automatic t_fetch();
    logic q; logic [1:0] c; logic [31:0] d;
    reg_wr(3'd5, 0);
    reg_wr(3'd0, 32'h0000_2000);
    reg_wr(3'd4, bpw(0, 0, 0, 2'b00, 2'b00));
    fetch(32'h2000, 0, q, c); chk("R5 disarmed no req", {31'd0, q}, 32'd0);
    reg_wr(3'd4, bpw(0, 0, 1, 2'b00, 2'b00));
    fetch(32'h2000, 0, q, c); chk("R5 global arms", {30'd0, q, c}, {29'd0, 3'b101});
    fetch(32'h2004, 0, q, c); chk("R13 pulse one cycle", {31'd0, q}, 32'd0);
    reg_rd(3'd5, d); chk("R6 hit bit0", d, 32'hFFFF_1FF1);
    reg_wr(3'd4, bpw(0, 1, 0, 2'b00, 2'b11));
    fetch(32'h2003, 0, q, c); chk("R6 4-byte window", {31'd0, q}, 32'd1);
    fetch(32'h2004, 0, q, c); chk("R6 outside window", {31'd0, q}, 32'd0);
    reg_wr(3'd4, bpw(0, 1, 0, 2'b00, 2'b10));
    fetch(32'h2000, 0, q, c); chk("R7 len 10 never", {31'd0, q}, 32'd0);
    reg_wr(3'd4, bpw(0, 1, 0, 2'b00, 2'b00));
    fetch(32'h2000, 1, q, c); chk("R10 resume masks fetch", {31'd0, q}, 32'd0);
    fetch(32'h2000, 0, q, c); chk("R10 fetch after resume", {31'd0, q}, 32'd1);
  endtask

  task automatic t_data();
    logic q; logic [1:0] c;
    reg_wr(3'd1, 32'h0000_1000);
    reg_wr(3'd4, bpw(1, 1, 0, 2'b01, 2'b11));
    dacc(32'h1003, 2'b00, 1, 0, q, c); chk("R8 write hit cause", {30'd0, q, c}, {29'd0, 3'b110});
    dacc(32'h1000, 2'b11, 0, 0, q, c); chk("R8 read ignored by type 01", {31'd0, q}, 32'd0);
    dacc(32'h0FFF, 2'b11, 1, 0, q, c); chk("R9 overlap from below", {31'd0, q}, 32'd1);
    dacc(32'h0FFC, 2'b01, 1, 0, q, c); chk("R9 no overlap", {31'd0, q}, 32'd0);
    fetch(32'h1000, 0, q, c); chk("R8 fetch ignored by data bp", {31'd0, q}, 32'd0);
    reg_wr(3'd4, bpw(1, 1, 0, 2'b11, 2'b01));
    dacc(32'h1001, 2'b00, 0, 0, q, c); chk("R8 read hits type 11", {31'd0, q}, 32'd1);
    dacc(32'h1000, 2'b00, 0, 1, q, c); chk("R8 io ignored by type 11", {31'd0, q}, 32'd0);
    reg_wr(3'd4, bpw(1, 1, 0, 2'b10, 2'b00));
    ext_en = 0;
    dacc(32'h1000, 2'b00, 0, 1, q, c); chk("R8 io type off without ext", {31'd0, q}, 32'd0);
    ext_en = 1;
    dacc(32'h1000, 2'b00, 0, 1, q, c); chk("R8 io type with ext", {31'd0, q}, 32'd1);
    dacc(32'h1000, 2'b00, 1, 0, q, c); chk("R8 memory ignored by io type", {31'd0, q}, 32'd0);
    ext_en = 0;
    reg_wr(3'd4, bpw(1, 1, 0, 2'b11, 2'b00));
    cyc(0, 0, 1, 32'h1000, 2'b00, 0, 0, 0, 0, 1, q, c);
    chk("R10 data not masked by resume", {31'd0, q}, 32'd1);
  endtask

  task automatic t_step();
    logic q; logic [1:0] c; logic [31:0] d;
    reg_wr(3'd4, 0);
    reg_wr(3'd5, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, q, c); chk("R11 first retire no trap", {31'd0, q}, 32'd0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, q, c); chk("R11 second retire traps", {30'd0, q, c}, {29'd0, 3'b111});
    reg_rd(3'd5, d); chk("R11 step bit", d, 32'hFFFF_5FF0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, q, c); chk("R11 flag clear no trap", {31'd0, q}, 32'd0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, q, c); chk("R11 rearm no trap", {31'd0, q}, 32'd0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, q, c); // disarm
  endtask

  task automatic t_collide();
    logic q; logic [1:0] c; logic [31:0] d;
    reg_wr(3'd5, 0);
    reg_wr(3'd0, 32'h0000_3000);
    reg_wr(3'd4, bpw(0, 1, 0, 2'b00, 2'b00));
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, q, c);
    cyc(1, 32'h3000, 0, 0, 0, 0, 0, 1, 1, 0, q, c);
    chk("R13 fetch wins over step", {30'd0, q, c}, {29'd0, 3'b101});
    reg_rd(3'd5, d); chk("R13 both recorded", d, 32'hFFFF_5FF1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, q, c);
    // multiple hits in one cycle
    reg_wr(3'd5, 0);
    reg_wr(3'd2, 32'h0000_3000);
    reg_wr(3'd4, bpw(0, 1, 0, 2'b00, 2'b00) | bpw(2, 0, 1, 2'b00, 2'b00));
    fetch(32'h3000, 0, q, c);
    reg_rd(3'd5, d); chk("R12 two hits one cycle", d, 32'hFFFF_1FF5);
    fetch(32'h3100, 0, q, c);
    reg_rd(3'd5, d); chk("R12 hits sticky", d, 32'hFFFF_1FF5);
    // status write in the same cycle as a hit
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_sel = 3'd5; reg_wdata = 0; fv = 1; fa = 32'h3000;
    @(posedge clk); #1;
    reg_req = 0; reg_we = 0; fv = 0;
    reg_rd(3'd5, d); chk("R12 hit beats clearing write", d, 32'hFFFF_1FF5);
    reg_wr(3'd5, 0);
    reg_rd(3'd5, d); chk("R12 write clears", d, 32'hFFFF_1FF0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_regs();
    t_priv();
    t_fetch();
    t_data();
    t_step();
    t_collide();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      nerr++; nchk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule